// File: doc/BRIEF.md
# Interruption State Capture Bank

This block holds twelve 64-bit control registers, indices 16 to 27, that record processor state when an interruption is taken. A handler then reads and writes them through an indexed access port. One status-collection flag (`ic_out`) gates both paths. While the flag is set, a taken interruption saves the current status word, instruction pointer and frame marker, and then clears the flag. While the flag is clear, software may access the bank, and further interruptions leave the saved context alone.

A separate cause register (index 17) records the vector, code and attribute flags of every interruption, whatever the flag says. The one exception is an event marked as a nested data translation fault. The saved status, pointer and frame are always presented together on dedicated outputs, for use by a return-from-interruption sequencer.

Top module: `intr_state_bank`

## Requirements
- R1: After reset every register in the bank reads as zero, `ic_out` is 0, and `fault_pulse` and `rd_data` are 0.
- R2: With `ic_out` at 0, an access to index 16..27 completes in one cycle. A write stores `acc_wdata`. A read places the register value on `rd_data` at the next clock edge. `rd_data` is 0 after any cycle without a permitted read.
- R3: An access to index 16..27 while `ic_out` is 1 raises `fault_pulse` for exactly one cycle, one edge after the access, and leaves the target register unchanged.
- R4: An interruption (`irq_take`) while `ic_out` is 1 loads index 16 with `status_in`, index 19 with `ip_in` and index 23 with `frame_in` zero-extended, and clears `ic_out` at the same edge.
- R5: An interruption while `ic_out` is 0 leaves indices 16, 19 and 23 unchanged.
- R6: Index 17 is written on every interruption regardless of `ic_out`, unless `irq_nested_dtlb` is 1, in which case index 17 keeps its value.
- R7: Index 17 layout: bits 15:0 code, bits 23:16 vector, bits 43:32 the attribute flags. The attribute input maps bit 0 to x, 1 to w, 2 to r, 3 to na, 4 to sp, 5 to rs, 6 to ir, 7 to ni, 8 to so, 10:9 to ei and 11 to ed. Bits 31:24 and 63:44 always read 0, including after a software write of all ones.
- R8: Several attribute flags set by one event are all retained: r and w together (semaphore fault), sp and r together (speculative load fault).
- R9: `rfi_status`, `rfi_ip` and `rfi_frame` always equal the contents of indices 16, 19 and 23, the last truncated to the frame width.
- R10: When a software write to index 17 and an interruption land in the same cycle, the interruption's value is stored. When `ic_we` and `irq_take` land together, `ic_out` becomes 0.
- R11: With no interruption, `ic_we` loads `ic_val` into `ic_out`. Indices without a capture source, such as 20, keep the last software value across interruptions.
- R12: An access to an index outside 16..27 raises no fault, writes nothing and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_take | input | 1 | Interruption taken this cycle |
| irq_nested_dtlb | input | 1 | Event is a nested data translation fault |
| irq_attr | input | 12 | Attribute flags of the event |
| irq_vector | input | 8 | Vector number |
| irq_code | input | 16 | Cause-specific code |
| status_in | input | 64 | Current processor status word |
| ip_in | input | 64 | Current instruction pointer |
| frame_in | input | 38 | Current frame marker |
| ic_we | input | 1 | Software update of the collection flag |
| ic_val | input | 1 | New collection flag value |
| acc_en | input | 1 | Register access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 5 | Register index |
| acc_wdata | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| fault_pulse | output | 1 | Illegal-operation fault strobe |
| rfi_status | output | 64 | Saved status for return |
| rfi_ip | output | 64 | Saved instruction pointer for return |
| rfi_frame | output | 38 | Saved frame marker for return |
| ic_out | output | 1 | Current status-collection flag |

## Verification
The assertions assume that `irq_take` and the access port are sampled only after reset is released. They also assume that `status_in`, `ip_in` and `frame_in` are stable for the cycle of a capture. The directed bench holds every input low during reset. It changes inputs only on the falling edge, so each capture and access sees settled values. It deliberately lines up a software write with an interruption to reach the priority case, rather than leaving that overlap to chance.

// File: rtl/intr_state_bank.sv
module intr_state_bank #(
  parameter int DW    = 64,
  parameter int FMW   = 38,
  parameter int IW    = 5,
  parameter int BASE  = 16,
  parameter int NREG  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           irq_take,
  input  logic           irq_nested_dtlb,
  input  logic [11:0]    irq_attr,
  input  logic [7:0]     irq_vector,
  input  logic [15:0]    irq_code,
  input  logic [DW-1:0]  status_in,
  input  logic [DW-1:0]  ip_in,
  input  logic [FMW-1:0] frame_in,
  input  logic           ic_we,
  input  logic           ic_val,
  input  logic           acc_en,
  input  logic           acc_we,
  input  logic [IW-1:0]  acc_idx,
  input  logic [DW-1:0]  acc_wdata,
  output logic [DW-1:0]  rd_data,
  output logic           fault_pulse,
  output logic [DW-1:0]  rfi_status,
  output logic [DW-1:0]  rfi_ip,
  output logic [FMW-1:0] rfi_frame,
  output logic           ic_out
);
  localparam int SW   = $clog2(NREG);
  localparam int S_ST = 0;
  localparam int S_CS = 1;
  localparam int S_IP = 3;
  localparam int S_FM = 7;
  localparam logic [DW-1:0] CS_MASK = DW'(44'h0FFF_00FF_FFFF);

  logic [DW-1:0] bank [NREG];
  logic          ic_q;

  wire           in_rng  = (int'(acc_idx) >= BASE) && (int'(acc_idx) < BASE + NREG);
  wire [SW-1:0]  slot    = SW'(acc_idx - IW'(BASE));
  wire           sw_ok   = acc_en && in_rng && !ic_q;
  wire           grab    = irq_take && ic_q;
  wire           cs_load = irq_take && !irq_nested_dtlb;
  wire [DW-1:0]  cs_new  = DW'({irq_attr, 8'h00, irq_vector, irq_code});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
      ic_q        <= 1'b0;
      fault_pulse <= 1'b0;
      rd_data     <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (sw_ok && acc_we && int'(slot) == i)
          bank[i] <= (i == S_CS) ? (acc_wdata & CS_MASK) : acc_wdata;
      if (grab) begin
        bank[S_ST] <= status_in;
        bank[S_IP] <= ip_in;
        bank[S_FM] <= DW'(frame_in);
      end
      if (cs_load) bank[S_CS] <= cs_new;
      if (irq_take)   ic_q <= 1'b0;
      else if (ic_we) ic_q <= ic_val;
      fault_pulse <= acc_en && in_rng && ic_q;
      rd_data     <= (sw_ok && !acc_we) ? bank[slot] : '0;
    end
  end

  assign ic_out     = ic_q;
  assign rfi_status = bank[S_ST];
  assign rfi_ip     = bank[S_IP];
  assign rfi_frame  = bank[S_FM][FMW-1:0];

  assert_fault_on_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && in_rng && ic_out) |=> fault_pulse);
  assert_fault_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pulse && !$past(acc_en)) |-> 1'b0);
  assert_capture_clears_ic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && ic_out) |=> (!ic_out && rfi_status == $past(status_in) && rfi_ip == $past(ip_in)));
  assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !ic_out && !acc_en) |=> ($stable(rfi_status) && $stable(rfi_ip) && $stable(rfi_frame)));
  assert_nested_keeps_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_nested_dtlb) |=> $stable(bank[S_CS]));
  assert_cause_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank[S_CS] & ~CS_MASK) == '0);
endmodule

// File: tb/intr_state_bank_bench.sv
module intr_state_bank_bench;
  logic clk = 0, rst_n = 0;
  logic irq_take = 0, irq_nested_dtlb = 0;
  logic [11:0] irq_attr = 0;
  logic [7:0]  irq_vector = 0;
  logic [15:0] irq_code = 0;
  logic [63:0] status_in = 0, ip_in = 0, acc_wdata = 0;
  logic [37:0] frame_in = 0;
  logic ic_we = 0, ic_val = 0, acc_en = 0, acc_we = 0;
  logic [4:0]  acc_idx = 0;
  logic [63:0] rd_data, rfi_status, rfi_ip;
  logic [37:0] rfi_frame;
  logic fault_pulse, ic_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  intr_state_bank u_intr_state_bank (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] cs(input logic [11:0] a, input logic [7:0] v, input logic [15:0] c);
    return {20'h0, a, 8'h00, v, c};
  endfunction

  task automatic acc(input bit we, input logic [4:0] idx, input logic [63:0] d);
    acc_en = 1; acc_we = we; acc_idx = idx; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(input logic [4:0] idx, input logic [63:0] exp, input string req);
    acc(0, idx, 0);
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic set_ic(input bit v);
    ic_we = 1; ic_val = v;
    @(negedge clk);
    ic_we = 0;
  endtask

  task automatic irq(input bit nested, input logic [11:0] a, input logic [7:0] v, input logic [15:0] c,
                     input logic [63:0] st, input logic [63:0] ip, input logic [37:0] fm);
    irq_take = 1; irq_nested_dtlb = nested; irq_attr = a; irq_vector = v; irq_code = c;
    status_in = st; ip_in = ip; frame_in = fm;
    @(negedge clk);
    irq_take = 0; irq_nested_dtlb = 0;
  endtask

  task automatic t_reset;
    chk(ic_out == 0, "R1 ic", 64'(ic_out), 0);
    chk(fault_pulse == 0 && rd_data == 0, "R1 outputs", rd_data, 0);
    chk(rfi_status == 0 && rfi_ip == 0 && rfi_frame == 0, "R1 saved", rfi_status, 0);
    rd(5'd27, 0, "R1 reg27");
  endtask

  task automatic t_rw;
    acc(1, 5'd20, 64'hA5A5_1234_5678_9ABC);
    chk(rd_data == 0, "R2 write rd zero", rd_data, 0);
    rd(5'd20, 64'hA5A5_1234_5678_9ABC, "R2 read20");
    acc(1, 5'd27, 64'h0F0F_0F0F_0F0F_0F0F);
    rd(5'd27, 64'h0F0F_0F0F_0F0F_0F0F, "R2 read27");
    acc(1, 5'd17, '1);
    rd(5'd17, 64'h0000_0FFF_00FF_FFFF, "R7 reserved zero");
  endtask

  task automatic t_capture;
    set_ic(1);
    chk(ic_out == 1, "R11 ic set", 64'(ic_out), 1);
    irq(0, 12'hABC, 8'h2D, 16'hBEEF, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 38'h3F_1234_5678);
    chk(ic_out == 0, "R4 ic cleared", 64'(ic_out), 0);
    chk(rfi_status == 64'h1111_2222_3333_4444, "R4 R9 status", rfi_status, 64'h1111_2222_3333_4444);
    chk(rfi_ip == 64'h5555_6666_7777_8888, "R4 R9 ip", rfi_ip, 64'h5555_6666_7777_8888);
    chk(rfi_frame == 38'h3F_1234_5678, "R4 R9 frame", 64'(rfi_frame), 64'h3F_1234_5678);
    rd(5'd23, 64'h3F_1234_5678, "R4 frame zero-ext");
    rd(5'd17, cs(12'hABC, 8'h2D, 16'hBEEF), "R7 layout");
    rd(5'd20, 64'hA5A5_1234_5678_9ABC, "R11 reg20 holds");
  endtask

  task automatic t_fault;
    set_ic(1);
    acc(1, 5'd20, 64'hDEAD);
    chk(fault_pulse == 1, "R3 fault", 64'(fault_pulse), 1);
    @(negedge clk);
    chk(fault_pulse == 0, "R3 single pulse", 64'(fault_pulse), 0);
    acc(0, 5'd5, 0);
    chk(fault_pulse == 0 && rd_data == 0, "R12 out of range locked", rd_data, 0);
    set_ic(0);
    rd(5'd20, 64'hA5A5_1234_5678_9ABC, "R3 unchanged");
  endtask

  task automatic t_ic0_irq;
    irq(0, 12'h001, 8'h11, 16'h0022, 64'hFFFF, 64'hEEEE, 38'h1);
    chk(rfi_status == 64'h1111_2222_3333_4444 && rfi_ip == 64'h5555_6666_7777_8888,
        "R5 saved kept", rfi_status, 64'h1111_2222_3333_4444);
    rd(5'd17, cs(12'h001, 8'h11, 16'h0022), "R6 cause with ic0");
  endtask

  task automatic t_nested;
    set_ic(1);
    irq(1, 12'hFFF, 8'hFF, 16'hFFFF, 64'h77, 64'h88, 38'h99);
    chk(rfi_status == 64'h77, "R4 nested still captures", rfi_status, 64'h77);
    rd(5'd17, cs(12'h001, 8'h11, 16'h0022), "R6 nested keeps cause");
  endtask

  task automatic t_multi;
    irq(0, 12'h006, 8'h24, 16'h0001, 0, 0, 0);
    rd(5'd17, cs(12'h006, 8'h24, 16'h0001), "R8 r+w");
    irq(0, 12'h014, 8'h1F, 16'h0002, 0, 0, 0);
    rd(5'd17, cs(12'h014, 8'h1F, 16'h0002), "R8 sp+r");
  endtask

  task automatic t_prio;
    acc_en = 1; acc_we = 1; acc_idx = 5'd17; acc_wdata = 64'h1234;
    ic_we = 1; ic_val = 1;
    irq(0, 12'h100, 8'h40, 16'h0BAD, 0, 0, 0);
    acc_en = 0; acc_we = 0; ic_we = 0;
    chk(ic_out == 0, "R10 irq beats ic set", 64'(ic_out), 0);
    rd(5'd17, cs(12'h100, 8'h40, 16'h0BAD), "R10 irq beats write");
  endtask

  task automatic t_range;
    acc(1, 5'd28, 64'h55);
    chk(fault_pulse == 0, "R12 no fault", 64'(fault_pulse), 0);
    rd(5'd28, 0, "R12 read zero");
    rd(5'd15, 0, "R12 low index");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_capture();
    t_fault();
    t_ic0_irq();
    t_nested();
    t_multi();
    t_prio();
    t_range();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual %h expected %h", 64'd0, 64'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule